// File: doc/BRIEF.md
# Oversampled Line-State Packer

This block listens to a full/low-speed USB line through an external transceiver whose transmitter is kept disabled. It runs on a 48 MHz sample clock, four samples per 12 MHz full-speed bit. On every clock it takes three receiver outputs: the differential receive bit and the single-ended D+ and D- levels. Each of these passes through one synchronizer flop. The block gathers five consecutive 3-bit samples into one 16-bit word. The top bit of that word is a pad bit, always 0.

Each finished word is offered on a valid/ready stream to a synchronous FIFO that runs on the same clock. The sink's ready is the inverse of the FIFO full flag. The stream never stalls, because the line cannot be paused. `out_valid` is a single-cycle pulse. The word is accepted only if `out_ready` is high in that same cycle. A word offered while `out_ready` is low is lost, and a sticky overflow flag is raised.

`cap_en` gates capture. Dropping it throws away a partly gathered word and restarts the sample count, so the next word always starts on a fresh group of five. Decoding of the line protocol and recovery of the bit clock are left to whatever reads the FIFO.

Top module: `line_state_packer`

## Requirements
- R1: While `rst_n` is low and after its release, `out_valid` is 0, `out_data` is 0 and `overflow` is 0 until capture produces a word.
- R2: Each sample written into a word is the value that the receiver inputs had at the clock edge one cycle before the edge that stores the sample (exactly one synchronizer stage).
- R3: Sample k of a word (k = 0 oldest to 4 newest) sits in bits [3k+2:3k], with bit 3k+2 = `rx_diff`, bit 3k+1 = `rx_dm`, bit 3k = `rx_dp`.
- R4: Bit 15 of every word presented on `out_data` is 0.
- R5: With `cap_en` high, every fifth sampling edge completes a word, and `out_valid` is high for exactly one cycle after that edge. With `cap_en` held high, consecutive pulses are exactly 5 cycles apart. No sample is lost or duplicated.
- R6: A cycle with `cap_en` low discards any partly gathered samples and restarts the count at zero. No word ever contains samples from before that cycle.
- R7: `out_valid` is never held waiting for `out_ready`. A word presented while `out_ready` is low is dropped, and `overflow` reads 1 from the next cycle on.
- R8: `overflow` stays 1 regardless of later traffic or `out_ready`, and returns to 0 only on reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 48 MHz sample and FIFO clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_en | input | 1 | Capture enable; low discards a partial word |
| rx_diff | input | 1 | Transceiver differential receive output (raw) |
| rx_dp | input | 1 | Transceiver D+ single-ended level (raw) |
| rx_dm | input | 1 | Transceiver D- single-ended level (raw) |
| out_ready | input | 1 | Sink can take a word (inverse of FIFO full) |
| out_data | output | 16 | Packed word: five samples plus pad bit 15 |
| out_valid | output | 1 | One-cycle strobe marking a new word |
| overflow | output | 1 | Sticky: a word was dropped for lack of ready |

## Verification
Several input patterns are used, and each one rules out a different class of error:
- An all-zero line catches a wrong pad bit or stray bits.
- A walking one across the three inputs tells apart the three signal positions inside a sample.
- A counting pattern, with a new value every clock, exposes a wrong sample order, a missing synchronizer stage or an extra one.
- A pseudo-random stretch mixes all of these.

A burst of three enabled cycles followed by a gap shows that partial words are discarded. A window with ready low, followed by normal traffic and then a reset, shows that overflow is set, that it sticks, and that it clears.

// File: rtl/lsp_pkg.sv
package lsp_pkg;
  // One captured line state; bit 2 = rcv, bit 1 = vm, bit 0 = vp.
  localparam int unsigned LINE_W = 3;
  typedef struct packed {
    logic rcv;
    logic vm;
    logic vp;
  } line_t;
endpackage

// File: rtl/lsp_sync.sv
module lsp_sync #(
  parameter int unsigned W = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[i] <= 1'b0;
      else        q[i] <= d[i];
    end
  end

  AST_ONE_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (q == $past(d))); // R2
endmodule

// File: rtl/lsp_gather.sv
module lsp_gather #(
  parameter int unsigned SW    = 3,
  parameter int unsigned N     = 5,
  parameter int unsigned CNT_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic [SW-1:0]   sample,
  output logic            fire,
  output logic [SW*N-1:0] pack
);
  localparam int unsigned SLOT_IW = (N > 2) ? $clog2(N-1) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(N-1);

  logic [CNT_W-1:0]        cnt;
  logic [N-2:0][SW-1:0]    slots;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      slots <= '0;
    end else if (!en) begin
      cnt <= '0;
    end else if (cnt == LAST) begin
      cnt <= '0;
    end else begin
      slots[cnt[SLOT_IW-1:0]] <= sample;
      cnt <= cnt + 1'b1;
    end
  end

  assign fire = en && (cnt == LAST);
  assign pack = {sample, slots};

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= LAST); // R5
  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt == '0)); // R6
endmodule

// File: rtl/lsp_emit.sv
module lsp_emit #(
  parameter int unsigned PW     = 15,
  parameter int unsigned WORD_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fire,
  input  logic [PW-1:0]     pack,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              overflow
);
  localparam int unsigned PAD_W = WORD_W - PW;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_data  <= '0;
      out_valid <= 1'b0;
      overflow  <= 1'b0;
    end else begin
      out_valid <= fire;
      if (fire) out_data <= {{PAD_W{1'b0}}, pack};
      if (out_valid && !out_ready) overflow <= 1'b1;
    end
  end

  AST_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid); // R5
  AST_DROP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> overflow); // R7
  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow); // R8
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data[WORD_W-1:PW] == '0)); // R4
endmodule

// File: rtl/line_state_packer.sv
module line_state_packer #(
  parameter int unsigned SAMPLES = 5,
  parameter int unsigned WORD_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic              rx_diff,
  input  logic              rx_dp,
  input  logic              rx_dm,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic              out_valid,
  output logic              overflow
);
  import lsp_pkg::*;

  localparam int unsigned PACK_W = LINE_W * SAMPLES;
  localparam int unsigned CNT_W  = (SAMPLES > 1) ? $clog2(SAMPLES) : 1;

  line_t              raw_line;
  line_t              sync_line;
  logic               word_fire;
  logic [PACK_W-1:0]  word_pack;

  always_comb begin
    raw_line.rcv = rx_diff;
    raw_line.vm  = rx_dm;
    raw_line.vp  = rx_dp;
  end

  lsp_sync #(.W(LINE_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (raw_line),
    .q     (sync_line)
  );

  lsp_gather #(.SW(LINE_W), .N(SAMPLES), .CNT_W(CNT_W)) u_gather (
    .clk    (clk),
    .rst_n  (rst_n),
    .en     (cap_en),
    .sample (sync_line),
    .fire   (word_fire),
    .pack   (word_pack)
  );

  lsp_emit #(.PW(PACK_W), .WORD_W(WORD_W)) u_emit (
    .clk       (clk),
    .rst_n     (rst_n),
    .fire      (word_fire),
    .pack      (word_pack),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_valid (out_valid),
    .overflow  (overflow)
  );

  AST_NO_IDLE_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_en |=> !out_valid); // R6
endmodule

// File: tb/line_state_packer_bench.sv
module line_state_packer_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cap_en = 1'b0;
  logic        rx_diff = 1'b0;
  logic        rx_dp = 1'b0;
  logic        rx_dm = 1'b0;
  logic        out_ready = 1'b1;
  logic [15:0] out_data;
  logic        out_valid;
  logic        overflow;

  int total = 0;
  int fails = 0;

  logic [15:0] exp_q[$];
  logic [2:0]  slot_q[$];
  logic [2:0]  prev_raw = 3'd0;
  logic        exp_ovf = 1'b0;
  int          gap = 0;
  bit          had_prev = 1'b0;

  always #5 clk = ~clk;

  line_state_packer u_line_state_packer (
    .clk(clk), .rst_n(rst_n), .cap_en(cap_en),
    .rx_diff(rx_diff), .rx_dp(rx_dp), .rx_dm(rx_dm),
    .out_ready(out_ready), .out_data(out_data),
    .out_valid(out_valid), .overflow(overflow)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", total - fails, total);
  endtask

  // Driver: sets one cycle of stimulus and updates the expected-word model.
  // raw is {rx_diff, rx_dm, rx_dp} (R3 order).
  task automatic step(input logic en, input logic [2:0] raw, input logic rdy);
    @(negedge clk);
    cap_en = en;
    {rx_diff, rx_dm, rx_dp} = raw;
    out_ready = rdy;
    if (en) begin
      slot_q.push_back(prev_raw); // R2: one synchronizer stage
      if (slot_q.size() == 5) begin
        logic [15:0] w;
        w = 16'h0000;
        for (int i = 0; i < 5; i++) w[3*i +: 3] = slot_q[i]; // R3, R4
        exp_q.push_back(w);
        slot_q.delete();
      end
    end else begin
      slot_q.delete(); // R6
    end
    prev_raw = raw;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cap_en = 1'b0;
    {rx_diff, rx_dm, rx_dp} = 3'd0;
    out_ready = 1'b1;
    prev_raw = 3'd0;
    slot_q.delete();
    exp_ovf = 1'b0;
    had_prev = 1'b0;
    gap = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // Monitor: samples mid-cycle, pops expected words, checks overflow and cadence.
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n) begin
        chk(overflow == exp_ovf, "R7/R8 overflow", overflow, exp_ovf);
        gap++;
        if (out_valid) begin
          if (exp_q.size() == 0) begin
            chk(1'b0, "R6 unexpected word", out_data, 0);
          end else begin
            logic [15:0] e;
            e = exp_q.pop_front();
            chk(out_data == e, "R2/R3 word", out_data, e);
            chk(out_data[15] == 1'b0, "R4 pad", out_data[15], 0);
          end
          if (had_prev) chk(gap == 5, "R5 spacing", gap, 5);
          had_prev = 1'b1;
          gap = 0;
          if (!out_ready) exp_ovf = 1'b1; // R7
        end
        if (!cap_en) had_prev = 1'b0;
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    total++;
    $display("FAIL R5 watchdog expired actual=1 expected=0");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    do_reset();
    #2;
    chk(out_valid == 1'b0, "R1 valid", out_valid, 0);
    chk(out_data == 16'h0, "R1 data", out_data, 0);
    chk(overflow == 1'b0, "R1 overflow", overflow, 0);

    // all-zero line
    for (int i = 0; i < 10; i++) step(1'b1, 3'd0, 1'b1);
    // walking one across the three inputs
    for (int i = 0; i < 15; i++) step(1'b1, 3'(1 << (i % 3)), 1'b1);
    // counting pattern
    for (int i = 0; i < 20; i++) step(1'b1, 3'(i % 8), 1'b1);
    // partial word then gap: R6
    step(1'b0, 3'd0, 1'b1);
    for (int i = 0; i < 3; i++) step(1'b1, 3'd7, 1'b1);
    step(1'b0, 3'd5, 1'b1);
    step(1'b0, 3'd2, 1'b1);
    for (int i = 0; i < 10; i++) step(1'b1, 3'(i % 8), 1'b1);
    // pseudo-random line
    lfsr = 8'hA5;
    for (int i = 0; i < 40; i++) begin
      step(1'b1, lfsr[2:0], 1'b1);
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    end
    // back-pressure: R7
    for (int i = 0; i < 6; i++) step(1'b1, 3'(i + 1), 1'b0);
    for (int i = 0; i < 15; i++) step(1'b1, 3'(7 - (i % 8)), 1'b1);
    repeat (3) step(1'b0, 3'd0, 1'b1);
    #2;
    chk(overflow == 1'b1, "R8 sticky", overflow, 1);
    chk(exp_q.size() == 0, "R5 all words seen", exp_q.size(), 0);
    // reset clears overflow: R8
    do_reset();
    #2;
    chk(overflow == 1'b0, "R8 cleared by reset", overflow, 0);
    chk(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);
    for (int i = 0; i < 10; i++) step(1'b1, 3'(i % 8), 1'b1);
    repeat (3) step(1'b0, 3'd0, 1'b1);
    #2;
    chk(exp_q.size() == 0, "R5 words after reset", exp_q.size(), 0);
    summary();
    $finish;
  end
endmodule